// File: doc/BRIEF.md
# Compare-Match Processor Timer

This block is a per-processor timer that owns a 64-bit free-running up-count and raises one level-sensitive interrupt when that count reaches a programmed deadline. The count advances by one on each cycle in which an external tick-enable strobe is high, but only while a software-visible frequency register is nonzero. When the frequency register is zero, the count is treated as switched off and reads as zero.

Software reaches the timer through a simple register port that uses single-cycle write and read strobes, a word address, and read data that is registered one cycle after the read strobe. The port exposes a single deadline in two ways. One is an absolute 64-bit compare value, split across two words. The other is a relative 32-bit timer value, derived from the compare value as compare minus count. Writing the timer value moves the deadline to the current count plus the sign-extended written word. A control word holds an enable bit and a mask bit, and it also reports a read-only status bit. The status bit is kept separate from the mask, so software can poll a due deadline without taking the interrupt.

Top module: `cmp_timer`

## Requirements
- R1: After synchronous reset the control word reads 0, the compare value reads 0, the count reads 0, the frequency register reads 0x01800000 and `irq` is 0.
- R2: The control word is at address 0. Bit 0 is enable and bit 1 is mask, and both are read/write. Bit 2 is the read-only status bit: a written 1 in bit 2 is ignored, and bits 31:3 read as 0.
- R3: The compare value is read/write as two words: bits 31:0 at address 1 and bits 63:32 at address 2.
- R4: A read of address 3 (the timer value) returns the low 32 bits of (compare value minus effective count).
- R5: A write of word W to address 3 sets the compare value to the effective count plus W sign-extended to 64 bits.
- R6: Status reads 1 exactly when enable is 1 and the effective count is greater than or equal to the compare value. Status reads 0 whenever enable is 0.
- R7: `irq` is high one cycle after enable=1, status=1 and mask=0 hold together. It is not latched: it falls one cycle after the mask is set or the deadline is moved beyond the count.
- R8: The count increments by exactly one on each clock edge at which `tick_en` is 1 and the frequency register is nonzero, and it holds otherwise. The count reads at address 5 (bits 31:0) and address 6 (bits 63:32).
- R9: The frequency register is read/write at address 4. While it is zero, the count does not advance, the count reads as 0, and status and the timer value use 0 as the count. A nonzero value makes the held count visible again.
- R10: The comparison is unsigned over all 64 bits. A compare value with bit 63 set never fires at a small count, and a compare value at or below the count fires at once.
- R11: Address 7 reads as 0, and a write to it changes no other register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count advance strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Level interrupt request, registered |

## Verification
The bench builds the block with its default parameters: a 64-bit count, 32-bit data and the 0x01800000 frequency reset value. The tick strobe is under the bench's full control, so the count is known exactly. The bench sweeps the compare value and the written timer value through a window around the live count, covering negative, zero and positive offsets and the extreme 32-bit words. This reaches both sides of the greater-or-equal boundary and the sign-extension edge. Full-width compare values, such as a value with only the top bit set or all ones, exercise the unsigned 64-bit comparison. Switching the frequency register to zero and back covers the off state and the hold of the count.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_CMP_LO = 3'd1,
    REG_CMP_HI = 3'd2,
    REG_TVAL   = 3'd3,
    REG_FREQ   = 3'd4,
    REG_CNT_LO = 3'd5,
    REG_CNT_HI = 3'd6,
    REG_NONE   = 3'd7
  } reg_addr_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MASK_BIT = 1;
  localparam int CTRL_STAT_BIT = 2;

endpackage

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
  parameter int          CNT_W      = 64,
  parameter int          FREQ_W     = 32,
  parameter logic [31:0] FREQ_RESET = 32'h0180_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              freq_we,
  input  logic [FREQ_W-1:0] freq_wdata,
  output logic [FREQ_W-1:0] freq_q,
  output logic [CNT_W-1:0]  count_eff
);

  localparam logic [FREQ_W-1:0] FREQ_INIT = FREQ_W'(FREQ_RESET);

  logic [CNT_W-1:0] cnt_q;
  logic             run;

  assign run = tick_en && (freq_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_q <= FREQ_INIT;
    end else if (freq_we) begin
      freq_q <= freq_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // The count is treated as switched off while the frequency register is zero.
  assign count_eff = (freq_q == '0) ? '0 : cnt_q;

  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
    (tick_en && freq_q != '0) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!tick_en || freq_q == '0) |=> $stable(cnt_q));

endmodule

// File: rtl/cmp_timer_match.sv
module cmp_timer_match #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count_eff,
  input  logic [CNT_W-1:0] cmp_q,
  input  logic             en,
  input  logic             mask,
  output logic             status,
  output logic             irq_q
);

  logic due;

  // Full-width unsigned comparison.
  assign due    = (count_eff >= cmp_q);
  assign status = en && due;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= status && !mask;
    end
  end

  assert_irq_needs_unmasked_R7: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($past(en) && !$past(mask)));

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq_q);

endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count_eff,
  input  logic [DATA_W-1:0] freq_q,
  input  logic              status,
  output logic              en_q,
  output logic              mask_q,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              freq_we,
  output logic [DATA_W-1:0] freq_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int HI_W  = CNT_W - DATA_W;
  localparam int EXT_W = CNT_W - DATA_W;

  reg_addr_e        addr;
  logic [CNT_W-1:0] rel_ext;
  logic [CNT_W-1:0] remain;
  logic [DATA_W-1:0] rd_next;

  assign addr    = reg_addr_e'(bus_addr);
  assign rel_ext = {{EXT_W{bus_wdata[DATA_W-1]}}, bus_wdata};
  assign remain  = cmp_q - count_eff;

  assign freq_we    = bus_wr && (addr == REG_FREQ);
  assign freq_wdata = bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
      cmp_q  <= '0;
    end else if (bus_wr) begin
      case (addr)
        REG_CTRL: begin
          en_q   <= bus_wdata[CTRL_EN_BIT];
          mask_q <= bus_wdata[CTRL_MASK_BIT];
        end
        REG_CMP_LO: cmp_q[DATA_W-1:0]     <= bus_wdata;
        REG_CMP_HI: cmp_q[CNT_W-1:DATA_W] <= bus_wdata[HI_W-1:0];
        REG_TVAL:   cmp_q                 <= count_eff + rel_ext;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr)
      REG_CTRL: begin
        rd_next[CTRL_EN_BIT]   = en_q;
        rd_next[CTRL_MASK_BIT] = mask_q;
        rd_next[CTRL_STAT_BIT] = status;
      end
      REG_CMP_LO: rd_next = cmp_q[DATA_W-1:0];
      REG_CMP_HI: rd_next = DATA_W'(cmp_q[CNT_W-1:DATA_W]);
      REG_TVAL:   rd_next = remain[DATA_W-1:0];
      REG_FREQ:   rd_next = freq_q;
      REG_CNT_LO: rd_next = count_eff[DATA_W-1:0];
      REG_CNT_HI: rd_next = DATA_W'(count_eff[CNT_W-1:DATA_W]);
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_next;
    end
  end

  assert_tval_load_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && addr == REG_TVAL) |=> (cmp_q == $past(count_eff) + $past(rel_ext)));

  assert_ctrl_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && addr == REG_CTRL) |=> (bus_rdata[DATA_W-1:CTRL_STAT_BIT+1] == '0));

  assert_spare_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && addr == REG_NONE) |=> (bus_rdata == '0));

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int          CNT_W      = 64,
  parameter int          DATA_W     = 32,
  parameter logic [31:0] FREQ_RESET = 32'h0180_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  logic [DATA_W-1:0] freq_q;
  logic [DATA_W-1:0] freq_wdata;
  logic              freq_we;
  logic [CNT_W-1:0]  count_eff;
  logic [CNT_W-1:0]  cmp_q;
  logic              en_q;
  logic              mask_q;
  logic              status;

  cmp_timer_counter #(
    .CNT_W      (CNT_W),
    .FREQ_W     (DATA_W),
    .FREQ_RESET (FREQ_RESET)
  ) i_counter (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .freq_we    (freq_we),
    .freq_wdata (freq_wdata),
    .freq_q     (freq_q),
    .count_eff  (count_eff)
  );

  cmp_timer_regs #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) i_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .count_eff  (count_eff),
    .freq_q     (freq_q),
    .status     (status),
    .en_q       (en_q),
    .mask_q     (mask_q),
    .cmp_q      (cmp_q),
    .freq_we    (freq_we),
    .freq_wdata (freq_wdata),
    .bus_rdata  (bus_rdata)
  );

  cmp_timer_match #(
    .CNT_W (CNT_W)
  ) i_match (
    .clk       (clk),
    .rst       (rst),
    .count_eff (count_eff),
    .cmp_q     (cmp_q),
    .en        (en_q),
    .mask      (mask_q),
    .status    (status),
    .irq_q     (irq)
  );

  assert_irq_due_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(count_eff) >= $past(cmp_q)));

endmodule

// File: tb/test_cmp_timer.sv
`timescale 1ns/1ps
module test_cmp_timer;

  localparam int CNT_W  = 64;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst;
  logic              tick_en;
  logic              bus_wr;
  logic              bus_rd;
  logic [2:0]        bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [63:0] m_cnt;
  logic [63:0] m_cmp;
  logic        m_en;
  logic        m_mask;
  logic [31:0] m_freq;

  always #10 clk = ~clk;

  cmp_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_cmp_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [63:0] eff();
    return (m_freq == 32'd0) ? 64'd0 : m_cnt;
  endfunction

  function automatic logic exp_stat();
    return m_en && (eff() >= m_cmp);
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
    if (m_freq != 32'd0) m_cnt = m_cnt + 64'(n);
  endtask

  task automatic set_cmp(input logic [63:0] v);
    wr(3'd1, v[31:0]);
    wr(3'd2, v[63:32]);
    m_cmp = v;
  endtask

  task automatic set_ctrl(input logic [31:0] v);
    wr(3'd0, v);
    m_en = v[0];
    m_mask = v[1];
  endtask

  // Reads control (which also lets irq settle) and checks status and irq.
  task automatic chk_state(input string req);
    logic [31:0] d;
    rd(3'd0, d);
    chk({req, " ctrl"}, 64'(d), 64'({29'd0, exp_stat(), m_mask, m_en}));
    chk({req, " irq"}, 64'(irq), 64'(exp_stat() && !m_mask));
  endtask

  task automatic chk_tval(input string req);
    logic [31:0] d;
    logic [63:0] diff;
    diff = m_cmp - eff();
    rd(3'd3, d);
    chk(req, 64'(d), 64'(diff[31:0]));
  endtask

  task automatic chk_cnt(input string req);
    logic [31:0] lo, hi;
    rd(3'd5, lo);
    rd(3'd6, hi);
    chk(req, {hi, lo}, eff());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, lo, hi;
    logic [31:0] tv [7];
    rst = 1'b1; tick_en = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    m_cnt = 0; m_cmp = 0; m_en = 0; m_mask = 0; m_freq = 32'h0180_0000;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    rd(3'd0, d);  chk("R1 ctrl", 64'(d), 64'd0);
    rd(3'd1, lo); rd(3'd2, hi); chk("R1 cmp", {hi, lo}, 64'd0);
    rd(3'd4, d);  chk("R1 freq", 64'(d), 64'h0180_0000);
    chk_cnt("R1 count");
    chk("R1 irq", 64'(irq), 64'd0);
    // R11: spare address
    rd(3'd7, d);  chk("R11 spare read", 64'(d), 64'd0);
    // R6: disabled with count >= compare
    chk_state("R6 disabled");

    // R8: counting
    ticks(100);
    chk_cnt("R8 count after 100");
    ticks(37);
    chk_cnt("R8 count after 137");

    // R3/R4/R6/R7: compare sweep around the count, unmasked and masked
    for (int msk = 0; msk < 2; msk++) begin
      set_ctrl(32'(1 | (msk << 1)));
      for (int off = -4; off <= 4; off++) begin
        set_cmp(m_cnt + 64'(signed'(off)));
        rd(3'd1, lo); rd(3'd2, hi);
        chk("R3 cmp readback", {hi, lo}, m_cmp);
        chk_state(msk ? "R7 masked sweep" : "R6 sweep");
        chk_tval("R4 tval sweep");
      end
    end

    // R2: status bit write ignored, upper bits zero
    set_cmp(m_cnt + 64'd50);
    set_ctrl(32'hFFFF_FFFC | 32'h1);
    chk_state("R2 status write ignored");
    set_ctrl(32'h0000_0005);
    chk_state("R2 status write ignored en");

    // R5/R4: relative writes, including sign extension edges
    tv[0] = 32'd0; tv[1] = 32'd1; tv[2] = 32'd5; tv[3] = 32'hFFFF_FFFF;
    tv[4] = 32'hFFFF_FFFB; tv[5] = 32'h7FFF_FFFF; tv[6] = 32'h8000_0000;
    for (int i = 0; i < 7; i++) begin
      wr(3'd3, tv[i]);
      m_cmp = m_cnt + {{32{tv[i][31]}}, tv[i]};
      rd(3'd1, lo); rd(3'd2, hi);
      chk("R5 tval write cmp", {hi, lo}, m_cmp);
      chk_tval("R4 tval readback");
      chk_state("R5 status after tval");
    end

    // R7: deadline approach, fire, mask, move ahead
    wr(3'd3, 32'd3);
    m_cmp = m_cnt + 64'd3;
    ticks(2);
    chk_state("R7 before deadline");
    ticks(1);
    chk_state("R7 at deadline");
    chk("R7 irq high", 64'(irq), 64'd1);
    set_ctrl(32'h3);
    chk_state("R7 mask drops irq");
    set_ctrl(32'h1);
    chk_state("R7 unmask raises irq");
    wr(3'd3, 32'd10);
    m_cmp = m_cnt + 64'd10;
    chk_state("R7 moved ahead");

    // R10: unsigned full-width compare
    set_cmp(64'h8000_0000_0000_0000);
    chk_state("R10 top bit");
    set_cmp(64'hFFFF_FFFF_FFFF_FFFF);
    chk_state("R10 all ones");
    chk_tval("R10 tval all ones");
    set_cmp(64'd0);
    chk_state("R10 zero fires");
    set_cmp({32'd1, 32'd0});
    chk_state("R10 high word");

    // R9: frequency zero switches the count off
    wr(3'd4, 32'd0); m_freq = 32'd0;
    rd(3'd4, d); chk("R9 freq readback", 64'(d), 64'd0);
    chk_cnt("R9 count reads zero");
    set_cmp(64'd0);
    chk_state("R9 off cmp zero");
    set_cmp(64'd1);
    chk_state("R9 off cmp one");
    chk_tval("R9 off tval");
    ticks(20);
    wr(3'd4, 32'd5); m_freq = 32'd5;
    rd(3'd4, d); chk("R9 freq nonzero", 64'(d), 64'd5);
    chk_cnt("R9 count held");
    ticks(4);
    chk_cnt("R8 count resumes");

    // R11: spare write has no effect
    rd(3'd1, lo);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, d); chk("R11 spare read after write", 64'(d), 64'd0);
    rd(3'd1, d); chk("R11 cmp unchanged", 64'(d), 64'(lo));
    chk_state("R11 ctrl unchanged");

    // R6: disable clears status and irq
    set_cmp(64'd0);
    chk_state("R6 enabled due");
    set_ctrl(32'h0);
    chk_state("R6 disabled again");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule